// File: doc/BRIEF.md
# Paged Extended Program Address Unit

This unit widens a 16-bit program counter into a 23-bit program fetch address. It does this by placing a 7-bit page register above the counter. Program space is split into 64K-word pages. Ordinary sequencing, near jumps and interrupts move only the low 16 bits, so they stay inside the current page.

The page can change in two ways. The first is one of six far control-flow operations: a far branch or far call to an immediate or accumulator target, and a far return with or without interrupt re-enable. The second is a data-space write to the page register at address 001Eh. A far call saves the full 23-bit return address on an 8-entry internal stack, and a far return restores both the page and the counter from that stack.

The instruction decoder supplies the operation class every cycle. For near flow it also supplies the next in-page counter value, and for calls it supplies the instruction length.

Top module: `far_pc_unit`

## Requirements
- R1: After synchronous reset the fetch address is 23'h00FF80: page 0, counter FF80h. The overflow and underflow flags are 0.
- R2: fetch_addr_o always equals {page[6:0], pc[15:0]}. With op code 0 (near), or with the unused code 7, the next cycle has pc = near_pc_i and an unchanged page.
- R3: Op code 1 (far branch) loads {page, pc} from target_i. Op code 2 (far branch via accumulator) loads them from acc_tgt_i. Either takes effect in the next cycle.
- R4: ret_addr_o = {page, pc + len_i}, with the 16-bit sum wrapping inside the page. Op code 3 (far call, target_i) and op code 4 (far call, acc_tgt_i) push ret_addr_o onto the stack and then branch.
- R5: Op code 5 (far return) and op code 6 (far return with interrupt enable) pop the most recent entry and load it into {page, pc}, in last-in first-out order.
- R6: ie_en_o is 1 in exactly the cycles where op_i is 6.
- R7: A write with dwr_en_i=1 to daddr_i=16'h001E during a near op sets page = dwdata_i[6:0] in the next cycle and ignores bits 15:7. Writes to any other address leave the page unchanged.
- R8: When a far op and a page-register write occur in the same cycle, the far op alone decides the next page.
- R9: drd_data_o = {9'b0, page} when daddr_i is 16'h001E, and 0 otherwise.
- R10: A far call with 8 entries already stacked drops the push, still branches, and sets ovf_o. ovf_o stays set until reset.
- R11: A far return with an empty stack leaves page and pc unchanged and sets udf_o. udf_o stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation class code |
| target_i | input | 23 | Immediate far target |
| acc_tgt_i | input | 23 | Accumulator bits [22:0] used as far target |
| near_pc_i | input | 16 | Next in-page counter value for near flow |
| len_i | input | 2 | Length of the current instruction in words |
| dwr_en_i | input | 1 | Data-space write strobe |
| daddr_i | input | 16 | Data-space address |
| dwdata_i | input | 16 | Data-space write data |
| drd_data_o | output | 16 | Data-space read data for the page register |
| fetch_addr_o | output | 23 | 23-bit program fetch address |
| ret_addr_o | output | 23 | Return address that a far call pushes |
| ie_en_o | output | 1 | Interrupt-enable request from a far return |
| ovf_o | output | 1 | Sticky return-stack overflow flag |
| udf_o | output | 1 | Sticky return-stack underflow flag |

## Verification
The assertions check the following on every cycle:
- Near flow keeps the page and takes the supplied counter.
- Both far branch variants land on their target.
- A page-register write lands in the page.
- The read port mirrors the page only at its address.
- Both error flags are sticky.

Some behaviour depends on history that a short property cannot hold, so only the bench scenarios show it:
- The last-in first-out order of returns across eight nested calls.
- The dropped push at overflow and the return addresses that follow it.
- The held state at underflow.
- The priority of a far op over a same-cycle register write.
- The full sweep of all 128 page values.

// File: rtl/far_pc_pkg.sv
package far_pc_pkg;
    localparam int PAGE_W   = 7;
    localparam int PC_W     = 16;
    localparam int ADDR_W   = PAGE_W + PC_W;
    localparam int DATA_W   = 16;
    localparam logic [DATA_W-1:0] PAGE_REG_ADDR = 16'h001E;
    localparam logic [PC_W-1:0]   RESET_PC      = 16'hFF80;

    typedef enum logic [2:0] {
        OP_NEAR  = 3'd0,
        OP_FB    = 3'd1,
        OP_FBACC = 3'd2,
        OP_FCALL = 3'd3,
        OP_FCALA = 3'd4,
        OP_FRET  = 3'd5,
        OP_FRETE = 3'd6
    } flow_op_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [PC_W-1:0]   pc;
    } prog_addr_t;

    function automatic logic op_is_call(input logic [2:0] op);
        return (op == OP_FCALL) || (op == OP_FCALA);
    endfunction

    function automatic logic op_is_ret(input logic [2:0] op);
        return (op == OP_FRET) || (op == OP_FRETE);
    endfunction
endpackage

// File: rtl/far_ret_stack.sv
module far_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 23
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SP_W  = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [SP_W-1:0] sp;
    logic [SP_W-1:0] sp_dec;

    assign full   = (sp == SP_W'(DEPTH));
    assign empty  = (sp == '0);
    assign sp_dec = sp - 1'b1;
    assign dout   = mem[IDX_W'(sp_dec)];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (push && !full) begin
            sp <= sp + 1'b1;
        end else if (pop && !empty) begin
            sp <= sp_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) begin
            mem[IDX_W'(sp)] <= din;
        end
    end
endmodule

// File: rtl/far_next_sel.sv
module far_next_sel
    import far_pc_pkg::*;
(
    input  logic [2:0]        op,
    input  prog_addr_t        cur,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] acc_tgt,
    input  logic [PC_W-1:0]   near_pc,
    input  logic              wr_hit,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [ADDR_W-1:0] pop_data,
    input  logic              stk_empty,
    output prog_addr_t        nxt,
    output logic              push,
    output logic              pop
);
    always_comb begin
        nxt  = cur;
        push = op_is_call(op);
        pop  = op_is_ret(op);
        case (op)
            OP_FB, OP_FCALL:    nxt = prog_addr_t'(target);
            OP_FBACC, OP_FCALA: nxt = prog_addr_t'(acc_tgt);
            OP_FRET, OP_FRETE: begin
                if (!stk_empty) nxt = prog_addr_t'(pop_data);
            end
            default: begin
                nxt.pc = near_pc;
                if (wr_hit) nxt.page = wr_page;
            end
        endcase
    end
endmodule

// File: rtl/far_pc_unit.sv
module far_pc_unit
    import far_pc_pkg::*;
#(
    parameter int STACK_DEPTH = 8,
    parameter int LEN_W       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [22:0]       target_i,
    input  logic [22:0]       acc_tgt_i,
    input  logic [15:0]       near_pc_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              dwr_en_i,
    input  logic [15:0]       daddr_i,
    input  logic [15:0]       dwdata_i,
    output logic [15:0]       drd_data_o,
    output logic [22:0]       fetch_addr_o,
    output logic [22:0]       ret_addr_o,
    output logic              ie_en_o,
    output logic              ovf_o,
    output logic              udf_o
);
    prog_addr_t        cur_q, nxt;
    logic              push, pop, full, empty, reg_hit;
    logic [ADDR_W-1:0] pop_data;
    logic              unused_wdata_hi;

    assign reg_hit         = (daddr_i == PAGE_REG_ADDR);
    assign unused_wdata_hi = ^dwdata_i[DATA_W-1:PAGE_W];

    assign fetch_addr_o = cur_q;
    assign ret_addr_o   = {cur_q.page, cur_q.pc + PC_W'(len_i)};
    assign ie_en_o      = (op_i == OP_FRETE);
    assign drd_data_o   = reg_hit ? DATA_W'(cur_q.page) : '0;

    far_next_sel u_sel (
        .op        (op_i),
        .cur       (cur_q),
        .target    (target_i),
        .acc_tgt   (acc_tgt_i),
        .near_pc   (near_pc_i),
        .wr_hit    (dwr_en_i && reg_hit),
        .wr_page   (dwdata_i[PAGE_W-1:0]),
        .pop_data  (pop_data),
        .stk_empty (empty),
        .nxt       (nxt),
        .push      (push),
        .pop       (pop)
    );

    far_ret_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (ret_addr_o),
        .dout  (pop_data),
        .full  (full),
        .empty (empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{page: '0, pc: RESET_PC};
            ovf_o <= 1'b0;
            udf_o <= 1'b0;
        end else begin
            cur_q <= nxt;
            ovf_o <= ovf_o | (push & full);
            udf_o <= udf_o | (pop & empty);
        end
    end
endmodule

// File: rtl/far_pc_unit_chk.sv
module far_pc_unit_chk
    import far_pc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_i,
    input logic [22:0] target_i,
    input logic [22:0] acc_tgt_i,
    input logic [15:0] near_pc_i,
    input logic        dwr_en_i,
    input logic [15:0] daddr_i,
    input logic [6:0]  wr_page,
    input logic [15:0] drd_data_o,
    input logic [22:0] fetch_addr_o,
    input logic        ovf_o,
    input logic        udf_o
);
    // R1
    reset_vec_chk: assert property (@(posedge clk)
        rst |=> (fetch_addr_o == 23'h00FF80 && !ovf_o && !udf_o));

    // R2
    near_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_NEAR || op_i == 3'd7) && !(dwr_en_i && daddr_i == PAGE_REG_ADDR))
        |=> (fetch_addr_o[22:16] == $past(fetch_addr_o[22:16]) &&
             fetch_addr_o[15:0] == $past(near_pc_i)));

    // R3
    fb_imm_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_FB) |=> (fetch_addr_o == $past(target_i)));

    // R3
    fb_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_FBACC) |=> (fetch_addr_o == $past(acc_tgt_i)));

    // R7
    page_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NEAR && dwr_en_i && daddr_i == PAGE_REG_ADDR)
        |=> (fetch_addr_o[22:16] == $past(wr_page)));

    // R9
    rd_other_chk: assert property (@(posedge clk) disable iff (rst)
        (daddr_i != PAGE_REG_ADDR) |-> (drd_data_o == 16'h0000));

    // R9
    rd_page_chk: assert property (@(posedge clk) disable iff (rst)
        (daddr_i == PAGE_REG_ADDR) |-> (drd_data_o == {9'b0, fetch_addr_o[22:16]}));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    // R11
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        udf_o |=> udf_o);
endmodule

bind far_pc_unit far_pc_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_i         (op_i),
    .target_i     (target_i),
    .acc_tgt_i    (acc_tgt_i),
    .near_pc_i    (near_pc_i),
    .dwr_en_i     (dwr_en_i),
    .daddr_i      (daddr_i),
    .wr_page      (dwdata_i[6:0]),
    .drd_data_o   (drd_data_o),
    .fetch_addr_o (fetch_addr_o),
    .ovf_o        (ovf_o),
    .udf_o        (udf_o)
);

// File: tb/far_pc_unit_bench.sv
module far_pc_unit_bench;
    import far_pc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = '0;
    logic [22:0] target_i = '0, acc_tgt_i = '0;
    logic [15:0] near_pc_i = '0, daddr_i = '0, dwdata_i = '0;
    logic [1:0]  len_i = '0;
    logic        dwr_en_i = 1'b0;
    logic [15:0] drd_data_o;
    logic [22:0] fetch_addr_o, ret_addr_o;
    logic        ie_en_o, ovf_o, udf_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [6:0]  m_page;
    logic [15:0] m_pc;
    logic [22:0] m_stk [8];
    int          m_sp;
    logic        m_ovf, m_udf;

    always #4 clk = ~clk;

    far_pc_unit u_far_pc_unit (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic [22:0] tgt, input logic [22:0] acc,
                        input logic [15:0] npc, input logic [1:0] len, input logic we,
                        input logic [15:0] addr, input logic [15:0] wd, input string tag);
        logic [22:0] ra;
        op_i = op; target_i = tgt; acc_tgt_i = acc; near_pc_i = npc;
        len_i = len; dwr_en_i = we; daddr_i = addr; dwdata_i = wd;
        #1;
        ra = {m_page, m_pc + 16'(len)};
        chk("R4 ret_addr", 32'(ret_addr_o), 32'(ra));
        chk("R6 ie_en", 32'(ie_en_o), 32'(op == 3'd6));
        chk("R9 read", 32'(drd_data_o), (addr == 16'h001E) ? 32'(m_page) : 32'h0);
        case (op)
            3'd1: {m_page, m_pc} = tgt;
            3'd2: {m_page, m_pc} = acc;
            3'd3, 3'd4: begin
                if (m_sp == 8) m_ovf = 1'b1;
                else begin m_stk[m_sp] = ra; m_sp++; end
                {m_page, m_pc} = (op == 3'd3) ? tgt : acc;
            end
            3'd5, 3'd6: begin
                if (m_sp == 0) m_udf = 1'b1;
                else begin m_sp--; {m_page, m_pc} = m_stk[m_sp]; end
            end
            default: begin
                m_pc = npc;
                if (we && addr == 16'h001E) m_page = wd[6:0];
            end
        endcase
        @(negedge clk);
        chk(tag, 32'(fetch_addr_o), 32'({m_page, m_pc}));
        chk("R10 ovf", 32'(ovf_o), 32'(m_ovf));
        chk("R11 udf", 32'(udf_o), 32'(m_udf));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_page = '0; m_pc = 16'hFF80; m_sp = 0; m_ovf = 0; m_udf = 0;
        // R1 reset state
        chk("R1 fetch", 32'(fetch_addr_o), 32'h00FF80);
        chk("R1 ovf", 32'(ovf_o), 0);
        chk("R1 udf", 32'(udf_o), 0);

        // R7 sweep every page value through the data port, upper data bits set
        for (int p = 0; p < 128; p++) begin
            step(3'd0, '0, '0, 16'(p * 517), 2'd1, 1'b1, 16'h001E,
                 {9'h1B5 ^ 9'(p), 7'(p)}, "R7 page write");
            step(3'd0, '0, '0, 16'(p * 3 + 1), 2'd2, 1'b0, 16'h001E, 16'hFFFF, "R2 near");
        end

        // R7 writes elsewhere ignored
        for (int a = 0; a < 64; a++) begin
            if (a != 16'h1E)
                step(3'd0, '0, '0, 16'(a), 2'd1, 1'b1, 16'(a), 16'hFFFF, "R7 other addr");
        end
        step(3'd7, '0, '0, 16'h1234, 2'd1, 1'b0, 16'h0000, 16'h0, "R2 code 7");

        // R3 far branches, immediate and accumulator
        for (int i = 0; i < 32; i++) begin
            step(3'd1, 23'(i * 32'h2B7C5 + 32'h1234), '0, 16'h0, 2'd1, 1'b0, 16'h0, 16'h0, "R3 FB");
            step(3'd2, '0, 23'(i * 32'h51A3 + 32'h7F0000), 16'h0, 2'd1, 1'b0, 16'h0, 16'h0, "R3 FBACC");
        end

        // R8 far op beats same-cycle page write
        step(3'd1, 23'h3A_1357, '0, 16'h0, 2'd1, 1'b1, 16'h001E, 16'h0055, "R8 FB vs write");
        step(3'd2, '0, 23'h11_2468, 16'h0, 2'd1, 1'b1, 16'h001E, 16'h0022, "R8 FBACC vs write");

        // R4 R10 nine calls, ninth overflows; len wraps near FFFF
        step(3'd1, 23'h05_FFFF, '0, 16'h0, 2'd1, 1'b0, 16'h0, 16'h0, "R3 setup");
        for (int i = 0; i < 9; i++) begin
            step((i % 2 == 0) ? 3'd3 : 3'd4, 23'(i * 32'h10_1111 + 32'hFFFE),
                 23'(i * 32'h0F_0F0F + 32'h20FFFF), 16'h0, 2'(i % 3 + 1), 1'b1, 16'h001E,
                 16'h007F, "R4 far call");
        end

        // R5 returns LIFO, alternating codes; then R11 underflow
        for (int i = 0; i < 9; i++) begin
            step((i % 2 == 0) ? 3'd5 : 3'd6, '0, '0, 16'hABCD, 2'd1, 1'b0, 16'h0, 16'h0,
                 (i == 8) ? "R11 underflow hold" : "R5 far return");
        end
        step(3'd6, '0, '0, 16'h0, 2'd1, 1'b0, 16'h001E, 16'h0, "R11 second underflow");
        step(3'd0, '0, '0, 16'h4242, 2'd1, 1'b0, 16'h001E, 16'h0, "R2 after errors");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule